// File: doc/BRIEF.md
# Repeated String Move Engine

This block executes a hardware-repeated byte string copy. It keeps three implicit architectural registers: a source pointer, a destination pointer and a remaining-byte count. A command supplies a two-byte instruction, a repeat prefix followed by a move-string opcode. When it decodes, the engine copies the string one byte per iteration until the count reaches zero: it reads the byte at the source pointer, writes it at the destination pointer, steps both pointers and lowers the count by one. The command carries no operands of its own. Everything it needs comes from the three registers.

Software loads the three registers through a load strobe while the engine is idle. A direction input, captured when the command is accepted, picks whether the pointers count up or down. The engine drives a single-port byte memory through a request/acknowledge handshake. All three registers can be read at any time, so their final values show how far the copy got. A byte pair that is not the expected instruction raises a one-cycle illegal-instruction flag and leaves everything untouched.

The controller has five states. IDLE waits for a load or a command. READ requests the source byte. WRITE stores it at the destination. FINISH raises done for one cycle. FAULT raises illegal for one cycle. Transitions:
- IDLE to READ on a legal command with a nonzero count.
- IDLE to FINISH on a legal command with a zero count.
- IDLE to FAULT on an illegal command.
- READ to WRITE on the read acknowledge.
- WRITE to READ on the write acknowledge while more than one byte is left.
- WRITE to FINISH on the write acknowledge for the last byte.
- FINISH to IDLE and FAULT to IDLE unconditionally.

Top module: `strmove_engine`

## Requirements
- R1: A command is legal when its first byte is 0xF2 and its second byte is 0xA4. A legal command accepted with a nonzero count makes busy high at the next sample and starts the copy.
- R2: Each iteration reads the byte at the source pointer (mem_we=0) and then writes that same byte at the destination pointer (mem_we=1). When the copy ends, the destination region holds the source bytes in the same order.
- R3: After each write acknowledge, both pointers step by one and the count falls by one. The pointers rise when dir_down was 0 at acceptance and fall when it was 1. They wrap modulo 2^16.
- R4: The copy stops when the count reaches zero. done is then high for exactly one cycle, after which busy is low. The count ends at 0, each pointer ends moved by the initial count, and exactly twice the initial count memory transfers have been acknowledged.
- R5: A legal command accepted with a count of zero makes no memory request and asserts done in the cycle after acceptance.
- R6: Any other byte pair (for example 0xF3,0xA4 or 0xF2,0xA5) asserts illegal for one cycle in the cycle after acceptance. It makes no memory request and leaves all three registers unchanged.
- R7: While idle, ld_en writes ld_src, ld_dst and ld_cnt into the three registers, visible one cycle later. While busy, ld_en has no effect.
- R8: After reset, all three registers read 0, busy, done and illegal are low, and no memory request is made.
- R9: Once a memory request is raised, it stays raised with a stable address, direction and write data until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_prefix | input | 8 | First instruction byte |
| cmd_opcode | input | 8 | Second instruction byte |
| dir_down | input | 1 | 1 = pointers decrement, 0 = increment; captured with the command |
| ld_en | input | 1 | Load strobe for the three registers, taken only when idle |
| ld_src | input | 16 | Source pointer load value |
| ld_dst | input | 16 | Destination pointer load value |
| ld_cnt | input | 16 | Count load value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ack on a read |
| mem_ack | input | 1 | One-cycle acknowledge that completes a request |
| busy | output | 1 | Engine not idle |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle illegal-instruction pulse |
| src_ptr | output | 16 | Source pointer register |
| dst_ptr | output | 16 | Destination pointer register |
| count | output | 16 | Remaining byte count |

## Verification
A wrong state or a wrong step shows at the ports within one iteration. A lost or doubled step leaves the pointers and the count off by one when done rises. It also changes the number of acknowledged transfers from twice the count. A wrong data latch shows up as corrupted destination bytes. A stuck direction shows as pointers that end on the wrong side of their start. A decode fault shows in the cycle right after acceptance, either as a missing illegal pulse or as a memory request where none may appear.

// File: rtl/strmove_pkg.sv
package strmove_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_FINISH,
        ST_FAULT
    } mv_state_t;
endpackage

// File: rtl/strmove_decode.sv
module strmove_decode #(
    parameter int          BW       = 8,
    parameter logic [BW-1:0] REP_CODE = 8'hF2,
    parameter logic [BW-1:0] MOV_CODE = 8'hA4
) (
    input  logic [BW-1:0] byte0,
    input  logic [BW-1:0] byte1,
    output logic          legal
);
    logic pfx_hit;
    logic op_hit;

    always_comb begin
        pfx_hit = (byte0 == REP_CODE);
        op_hit  = (byte1 == MOV_CODE);
        legal   = pfx_hit && op_hit;
    end
endmodule

// File: rtl/strmove_regs.sv
module strmove_regs #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ld_src,
    input  logic [AW-1:0] ld_dst,
    input  logic [CW-1:0] ld_cnt,
    input  logic          step,
    input  logic          down,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q,
    output logic [CW-1:0] cnt_q,
    output logic          cnt_zero,
    output logic          cnt_one
);
    localparam logic [AW-1:0] PTR_ONE = AW'(1);
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    logic [AW-1:0] src_next;
    logic [AW-1:0] dst_next;

    always_comb begin
        src_next = down ? (src_q - PTR_ONE) : (src_q + PTR_ONE);
        dst_next = down ? (dst_q - PTR_ONE) : (dst_q + PTR_ONE);
        cnt_zero = (cnt_q == '0);
        cnt_one  = (cnt_q == CNT_ONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            src_q <= ld_src;
            dst_q <= ld_dst;
            cnt_q <= ld_cnt;
        end else if (step) begin
            src_q <= src_next;
            dst_q <= dst_next;
            cnt_q <= cnt_q - CNT_ONE;
        end
    end

    // R4: a step never takes an empty count below zero
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !cnt_zero);

    // R6: with neither load nor step, the registers hold
    a_r6_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q)));
endmodule

// File: rtl/strmove_fsm.sv
module strmove_fsm
    import strmove_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_legal,
    input  logic          ld_en,
    input  logic          dir_in,
    input  logic          cnt_zero,
    input  logic          cnt_one,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] data_q,
    output logic          dir_q,
    output logic          load_ok,
    output logic          step,
    output logic          busy,
    output logic          done,
    output logic          illegal
);
    mv_state_t state_q;
    mv_state_t state_d;
    logic      accept;

    // next-state logic
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!ld_en && cmd_valid) begin
                    accept = 1'b1;
                    if (!cmd_legal)    state_d = ST_FAULT;
                    else if (cnt_zero) state_d = ST_FINISH;
                    else               state_d = ST_READ;
                end
            end
            ST_READ:   if (mem_ack) state_d = ST_WRITE;
            ST_WRITE:  if (mem_ack) state_d = cnt_one ? ST_FINISH : ST_READ;
            ST_FINISH: state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // captured direction and byte buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            data_q <= '0;
        end else begin
            if (accept)                         dir_q  <= dir_in;
            if (state_q == ST_READ && mem_ack)  data_q <= mem_rdata;
        end
    end

    // outputs
    always_comb begin
        mem_req = 1'b0;
        mem_we  = 1'b0;
        load_ok = 1'b0;
        step    = 1'b0;
        busy    = 1'b1;
        done    = 1'b0;
        illegal = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy    = 1'b0;
                load_ok = ld_en;
            end
            ST_READ:   mem_req = 1'b1;
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                step    = mem_ack;
            end
            ST_FINISH: done    = 1'b1;
            ST_FAULT:  illegal = 1'b1;
            default:   busy    = 1'b1;
        endcase
    end

    // R4: completion is a single-cycle pulse
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: illegal is a single-cycle pulse
    a_r6_illegal_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> !illegal);

    // R2: a read acknowledge is always followed by a write request
    a_r2_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we));
endmodule

// File: rtl/strmove_engine.sv
module strmove_engine #(
    parameter int          AW       = 16,
    parameter int          CW       = 16,
    parameter int          DW       = 8,
    parameter logic [7:0]  REP_CODE = 8'hF2,
    parameter logic [7:0]  MOV_CODE = 8'hA4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [7:0]    cmd_prefix,
    input  logic [7:0]    cmd_opcode,
    input  logic          dir_down,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_src,
    input  logic [AW-1:0] ld_dst,
    input  logic [CW-1:0] ld_cnt,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic          busy,
    output logic          done,
    output logic          illegal,
    output logic [AW-1:0] src_ptr,
    output logic [AW-1:0] dst_ptr,
    output logic [CW-1:0] count
);
    logic          legal;
    logic          load_ok;
    logic          step;
    logic          dir_q;
    logic          cnt_zero;
    logic          cnt_one;
    logic [DW-1:0] data_q;

    strmove_decode #(
        .BW       (8),
        .REP_CODE (REP_CODE),
        .MOV_CODE (MOV_CODE)
    ) u_decode (
        .byte0 (cmd_prefix),
        .byte1 (cmd_opcode),
        .legal (legal)
    );

    strmove_regs #(
        .AW (AW),
        .CW (CW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_ok),
        .ld_src   (ld_src),
        .ld_dst   (ld_dst),
        .ld_cnt   (ld_cnt),
        .step     (step),
        .down     (dir_q),
        .src_q    (src_ptr),
        .dst_q    (dst_ptr),
        .cnt_q    (count),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one)
    );

    strmove_fsm #(
        .DW (DW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_legal (legal),
        .ld_en     (ld_en),
        .dir_in    (dir_down),
        .cnt_zero  (cnt_zero),
        .cnt_one   (cnt_one),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .load_ok   (load_ok),
        .step      (step),
        .busy      (busy),
        .done      (done),
        .illegal   (illegal)
    );

    always_comb begin
        mem_addr  = mem_we ? dst_ptr : src_ptr;
        mem_wdata = data_q;
    end

    // R9: a pending request holds its address, direction and data
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R5: no memory traffic while idle
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R6: an illegal pulse never coincides with memory traffic
    a_r6_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !mem_req);
endmodule

// File: tb/test_strmove_engine.sv
module test_strmove_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_prefix = 8'h00;
    logic [7:0]  cmd_opcode = 8'h00;
    logic        dir_down = 1'b0;
    logic        ld_en = 1'b0;
    logic [15:0] ld_src = '0;
    logic [15:0] ld_dst = '0;
    logic [15:0] ld_cnt = '0;
    logic        mem_req;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic        mem_ack = 1'b0;
    logic        busy;
    logic        done;
    logic        illegal;
    logic [15:0] src_ptr;
    logic [15:0] dst_ptr;
    logic [15:0] count;

    int nchk = 0;
    int nerr = 0;
    int acks = 0;
    int wait_n = 0;
    int cyc_total = 0;

    logic [7:0] mem [0:4095];

    always #5 clk = ~clk;

    strmove_engine i_strmove_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_prefix(cmd_prefix),
        .cmd_opcode(cmd_opcode), .dir_down(dir_down), .ld_en(ld_en), .ld_src(ld_src),
        .ld_dst(ld_dst), .ld_cnt(ld_cnt), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .busy(busy), .done(done), .illegal(illegal),
        .src_ptr(src_ptr), .dst_ptr(dst_ptr), .count(count)
    );

    // memory model with random 0..2 cycle wait
    always @(posedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wait_n == 0) begin
                mem_ack <= 1'b1;
                acks    <= acks + 1;
                if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[11:0]];
                wait_n  <= int'($urandom % 3);
            end else begin
                wait_n <= wait_n - 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc_total <= cyc_total + 1;
        if (cyc_total > 150000) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc_total, 150000);
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    task automatic load_regs(input logic [15:0] s, input logic [15:0] d, input logic [15:0] n);
        @(negedge clk);
        ld_en = 1'b1; ld_src = s; ld_dst = d; ld_cnt = n;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // drives the command for one cycle; returns one sample after acceptance
    task automatic issue(input logic [7:0] b0, input logic [7:0] b1, input logic dn);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_prefix = b0; cmd_opcode = b1; dir_down = dn;
        @(negedge clk);
        cmd_valid = 1'b0; dir_down = ~dn;
    endtask

    function automatic logic [15:0] mv(input logic [15:0] base, input int k, input logic dn);
        return dn ? base - 16'(k) : base + 16'(k);
    endfunction

    task automatic run_copy(input logic [15:0] s0, input logic [15:0] d0, input int n,
                            input logic dn, input bit poke);
        logic [7:0] exp_b [0:63];
        int start;
        int cyc;
        for (int i = 0; i < n; i++) begin
            exp_b[i] = 8'($urandom);
            mem[mv(s0, i, dn) & 16'h0FFF] = exp_b[i];
            mem[mv(d0, i, dn) & 16'h0FFF] = ~exp_b[i];
        end
        load_regs(s0, d0, 16'(n));
        start = acks;
        issue(8'hF2, 8'hA4, dn);
        chk("R1 busy after legal command", busy, 1);
        cyc = 0;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 3) begin
                ld_en = 1'b1; ld_src = 16'h0BAD; ld_dst = 16'h0BAD; ld_cnt = 16'h0077;
            end else begin
                ld_en = 1'b0;
            end
        end
        ld_en = 1'b0;
        chk("R4 done reached", done, 1);
        chk("R4 count final", count, 0);
        chk("R3 src final", src_ptr, mv(s0, n, dn));
        chk("R3 dst final", dst_ptr, mv(d0, n, dn));
        chk("R4 transfers", acks - start, 2 * n);
        for (int i = 0; i < n; i++)
            chk("R2 dest byte", mem[mv(d0, i, dn) & 16'h0FFF], exp_b[i]);
        @(negedge clk);
        chk("R4 done one cycle", done, 0);
        chk("R4 idle after", busy, 0);
        if (poke) chk("R7 load ignored while busy", count, 0);
    endtask

    task automatic bad_cmd(input logic [7:0] b0, input logic [7:0] b1);
        int start;
        load_regs(16'h1234, 16'h5678, 16'h0009);
        start = acks;
        issue(b0, b1, 1'b0);
        chk("R6 illegal raised", illegal, 1);
        chk("R6 no request", mem_req, 0);
        @(negedge clk);
        chk("R6 illegal one cycle", illegal, 0);
        chk("R6 src kept", src_ptr, 16'h1234);
        chk("R6 dst kept", dst_ptr, 16'h5678);
        chk("R6 count kept", count, 16'h0009);
        chk("R6 no transfers", acks - start, 0);
    endtask

    initial begin
        int start;
        void'($urandom(32'd4471));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk("R8 src reset", src_ptr, 0);
        chk("R8 dst reset", dst_ptr, 0);
        chk("R8 count reset", count, 0);
        chk("R8 busy reset", busy, 0);
        chk("R8 done reset", done, 0);
        chk("R8 illegal reset", illegal, 0);
        chk("R8 no request", mem_req, 0);

        // R7 load while idle
        load_regs(16'hA1A1, 16'hB2B2, 16'h0C0C);
        chk("R7 src load", src_ptr, 16'hA1A1);
        chk("R7 dst load", dst_ptr, 16'hB2B2);
        chk("R7 count load", count, 16'h0C0C);

        // R5 zero count
        load_regs(16'h0100, 16'h0800, 16'h0000);
        start = acks;
        issue(8'hF2, 8'hA4, 1'b0);
        chk("R5 done next cycle", done, 1);
        chk("R5 no request", mem_req, 0);
        @(negedge clk);
        chk("R5 no transfers", acks - start, 0);
        chk("R5 src unchanged", src_ptr, 16'h0100);

        // R6 illegal encodings
        bad_cmd(8'hF3, 8'hA4);
        bad_cmd(8'hF2, 8'hA5);
        bad_cmd(8'hA4, 8'hF2);

        // directed boundaries: single byte, wrap up, wrap down, load during run
        run_copy(16'h0120, 16'h0820, 1, 1'b0, 1'b0);
        run_copy(16'hFFFE, 16'h0800, 4, 1'b0, 1'b0);
        run_copy(16'h0001, 16'h0900, 4, 1'b1, 1'b0);
        run_copy(16'h0140, 16'h0840, 20, 1'b0, 1'b1);

        // R2 R3 random runs
        for (int t = 0; t < 24; t++) begin
            logic dn;
            int n;
            logic [15:0] s0;
            logic [15:0] d0;
            dn = 1'($urandom);
            n  = 1 + int'($urandom % 64);
            s0 = (dn ? 16'h0300 : 16'h0100) + 16'($urandom % 256);
            d0 = (dn ? 16'h0A00 : 16'h0800) + 16'($urandom % 256);
            run_copy(s0, d0, n, dn, 1'($urandom % 4 == 0));
        end

        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule